// File: doc/BRIEF.md
# EEPROM Page Write Buffer and Commit Unit

This unit sits behind a two-wire serial slave engine inside a byte-addressed EEPROM model. Once the engine has decoded a write command's select and address bytes, it loads the start address and the write-protect decision into the unit. The engine then forwards each data byte as a one-cycle strobe. Bytes go into a 64-byte page latch at the column offset held in an internal address counter. A per-column valid mask records which positions were actually written.

When the command closes with a STOP, the unit starts a self-timed programming cycle, provided the command was unprotected and carried at least one byte. The cycle walks the 64 columns once, one per cycle. It drives the memory write port only for columns whose valid bit is set. It then holds busy until a parameterised number of system-clock cycles has elapsed. While busy is high, every command input is ignored, including new command loads. When the cycle ends, busy drops and the mask is cleared.

A single data byte is simply the one-byte case of a page. The backing store is a register array whose size is set by parameter. It powers up erased to 8'hFF and has an asynchronous read port.

Top module: `eep_page_commit`

## Requirements
- R1: On a cmd_load_i pulse the address counter takes addr_i, and addr_o shows it on the next cycle. Each accepted data byte is stored at column addr_o[5:0] and then increments only the column, wrapping from 63 to 0. The row field addr_o[ADDR_W-1:6] never changes within a command.
- R2: If more than 64 bytes arrive in one command, a later byte at the same column replaces the earlier one, and only the last value is committed.
- R3: A stop_i pulse after an unprotected command holding at least one byte raises busy_o on the next cycle. busy_o then stays high for exactly PROG_CYCLES cycles.
- R4: In busy cycle k, for k from 0 to 63, mem_we_o is high exactly when column k was written, with mem_addr_o = {row, k} and mem_wdata_o equal to the latched byte. mem_we_o never rises outside those cycles, and unwritten bytes of the row keep their values.
- R5: A stop_i after a command with zero data bytes, or with no open command, does not raise busy_o and writes nothing.
- R6: If wp_i is high at cmd_load_i, that command's bytes are neither latched nor counted, addr_o does not advance, and its stop_i starts no cycle.
- R7: While busy_o is high, cmd_load_i, byte_valid_i and stop_i have no effect. addr_o stays unchanged, and no cycle follows on a later stop_i without a new load.
- R8: After a cycle ends, the valid mask is empty. The next command commits only its own columns.
- R9: After reset, busy_o and mem_we_o are 0, addr_o is 0, and every memory byte reads 8'hFF.
- R10: rd_data_o equals the array byte at rd_addr_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_load_i | input | 1 | Pulse: write command address phase complete |
| addr_i | input | ADDR_W | Start byte address of the command |
| wp_i | input | 1 | Write-protect decision for the command |
| byte_valid_i | input | 1 | Pulse: data byte received |
| byte_data_i | input | 8 | Data byte |
| stop_i | input | 1 | Pulse: STOP condition seen |
| busy_o | output | 1 | Programming cycle in progress |
| addr_o | output | ADDR_W | Current address counter |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data |

## Verification
The bench builds the unit with ADDR_W = 9 and PROG_CYCLES = 80. With 8 rows, random start addresses hit the same rows often, so later commands land on bytes that earlier ones programmed, and the checks on unwritten bytes keeping their values carry weight. With a cycle only 16 cycles longer than the column walk, every busy cycle can be checked one by one, including the tail after the last write and an injection of command inputs in the middle of a cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int COL_W      = 6;
  localparam int PAGE_BYTES = 1 << COL_W;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/eep_page_latch.sv
module eep_page_latch
  import eep_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic               clear_i,
  input  logic               cmd_load_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wp_i,
  input  logic               byte_valid_i,
  input  byte_t              byte_data_i,
  input  logic               stop_i,
  input  logic [COL_W-1:0]   sel_col_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [ADDR_W-COL_W-1:0] row_o,
  output logic               commit_go_o,
  output byte_t              sel_data_o,
  output logic               sel_valid_o
);
  localparam int ROW_W = ADDR_W - COL_W;

  logic [ROW_W-1:0]      row_q;
  logic [COL_W-1:0]      col_q;
  logic                  wp_q, active_q;
  logic [PAGE_BYTES-1:0] mask_q;
  byte_t                 page_q [PAGE_BYTES];

  logic accept_cmd, accept_stop, accept_byte;

  assign accept_cmd  = cmd_load_i & ~busy_i;
  assign accept_stop = stop_i & ~busy_i & ~cmd_load_i;
  assign accept_byte = byte_valid_i & active_q & ~wp_q & ~busy_i & ~cmd_load_i & ~stop_i;
  assign commit_go_o = accept_stop & active_q & ~wp_q & (|mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q    <= '0;
      col_q    <= '0;
      wp_q     <= 1'b0;
      active_q <= 1'b0;
      mask_q   <= '0;
    end else if (clear_i) begin
      mask_q <= '0;
    end else if (accept_cmd) begin
      row_q    <= addr_i[ADDR_W-1:COL_W];
      col_q    <= addr_i[COL_W-1:0];
      wp_q     <= wp_i;
      active_q <= 1'b1;
      mask_q   <= '0;
    end else if (accept_stop) begin
      active_q <= 1'b0;
    end else if (accept_byte) begin
      mask_q[col_q] <= 1'b1;
      col_q         <= col_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept_byte) page_q[col_q] <= byte_data_i;
  end

  assign addr_o      = {row_q, col_q};
  assign row_o       = row_q;
  assign sel_data_o  = page_q[sel_col_i];
  assign sel_valid_o = mask_q[sel_col_i];

  assert_col_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_byte && (col_q == '1) |=> (col_q == '0));
  assert_row_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_load_i |=> $stable(row_q));
  assert_protect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_q && !cmd_load_i |=> $stable(mask_q) && $stable(col_q));
  assert_busy_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(row_q) && $stable(col_q) && $stable(active_q));
  assert_mask_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (mask_q == '0));
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int PROG_CYCLES = 5000,
  parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_q & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  initial assert_min_len_R3: assert (PROG_CYCLES > 64);

  assert_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_q && (cnt_q == '0));
  assert_busy_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cnt_q != LAST) |=> busy_q && (cnt_q == $past(cnt_q) + 1'b1));
  assert_busy_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cnt_q == LAST) |=> !busy_q);
endmodule

// File: rtl/eep_array.sv
module eep_array
  import eep_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  byte_t             wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output byte_t             rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  assert_write_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/eep_page_commit.sv
module eep_page_commit
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PROG_CYCLES = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam int ROW_W = ADDR_W - COL_W;

  logic             busy, done, commit_go, sel_valid, walk;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] sel_col;
  byte_t            sel_data;

  assign sel_col = cnt[COL_W-1:0];
  assign walk    = busy & (cnt < CNT_W'(PAGE_BYTES));

  eep_page_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk_i, .rst_ni,
    .busy_i      (busy),
    .clear_i     (done),
    .cmd_load_i, .addr_i, .wp_i, .byte_valid_i, .byte_data_i, .stop_i,
    .sel_col_i   (sel_col),
    .addr_o      (addr_o),
    .row_o       (row),
    .commit_go_o (commit_go),
    .sel_data_o  (sel_data),
    .sel_valid_o (sel_valid)
  );

  eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .start_i (commit_go),
    .busy_o  (busy),
    .done_o  (done),
    .cnt_o   (cnt)
  );

  assign mem_we_o    = walk & sel_valid;
  assign mem_addr_o  = {row, sel_col};
  assign mem_wdata_o = sel_data;
  assign busy_o      = busy;

  eep_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni,
    .we_i    (mem_we_o),
    .waddr_i (mem_addr_o),
    .wdata_i (mem_wdata_o),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assert_we_in_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  assert_we_row_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:COL_W] == addr_o[ADDR_W-1:COL_W]));
  assert_no_start_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !stop_i |=> !busy_o);
endmodule

// File: tb/eep_page_commit_test.sv
module eep_page_commit_test;
  localparam int AW = 9;
  localparam int PC = 80;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cmd_load = 0, wp = 0, bvalid = 0, stop = 0;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [7:0]    bdata = '0;
  logic          busy, mem_we;
  logic [AW-1:0] addr_out, mem_addr;
  logic [7:0]    mem_wdata, rd_data;

  eep_page_commit #(.ADDR_W(AW), .PROG_CYCLES(PC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_load_i(cmd_load), .addr_i(addr), .wp_i(wp),
    .byte_valid_i(bvalid), .byte_data_i(bdata), .stop_i(stop),
    .busy_o(busy), .addr_o(addr_out), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0]    m_mem [DEPTH];
  logic [7:0]    m_lat [64];
  logic [63:0]   m_val;
  logic [AW-7:0] m_row;
  logic [5:0]    m_col;
  logic          m_wp, m_act;

  function automatic logic [AW-1:0] exp_addr();
    return {m_row, m_col};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic w);
    cmd_load = 1; addr = a; wp = w;
    @(negedge clk);
    cmd_load = 0; wp = 0;
    m_row = a[AW-1:6]; m_col = a[5:0]; m_wp = w; m_act = 1; m_val = '0;
    chk(addr_out == exp_addr(), "R1 load", addr_out, exp_addr());
  endtask

  task automatic do_byte(input logic [7:0] d);
    bvalid = 1; bdata = d;
    @(negedge clk);
    bvalid = 0;
    if (m_act && !m_wp) begin
      m_lat[m_col] = d; m_val[m_col] = 1'b1; m_col = m_col + 1'b1;
    end
    chk(addr_out == exp_addr(), m_wp ? "R6 addr" : "R1 addr", addr_out, exp_addr());
  endtask

  task automatic check_row(input logic [AW-7:0] r);
    for (int c = 0; c < 64; c++) begin
      rd_addr = {r, c[5:0]};
      #1;
      chk(rd_data == m_mem[rd_addr], "R4 row", rd_data, m_mem[rd_addr]);
    end
  endtask

  // poke_at >= 0 injects command inputs in that busy cycle (R7)
  task automatic do_stop(input int poke_at);
    logic go;
    go = m_act && !m_wp && (m_val != 0);
    stop = 1;
    @(negedge clk);
    stop = 0;
    m_act = 0;
    chk(busy == go, go ? "R3 start" : "R5 no start", busy, go);
    if (go) begin
      for (int k = 0; k < PC; k++) begin
        chk(busy == 1'b1, "R3 hold", busy, 1);
        if (k < 64) begin
          chk(mem_we == m_val[k], "R4 we", mem_we, m_val[k]);
          if (mem_we) begin
            chk(mem_addr == {m_row, k[5:0]}, "R4 addr", mem_addr, {m_row, k[5:0]});
            chk(mem_wdata == m_lat[k], "R2 data", mem_wdata, m_lat[k]);
            m_mem[{m_row, k[5:0]}] = m_lat[k];
          end
        end else begin
          chk(mem_we == 1'b0, "R4 tail", mem_we, 0);
        end
        if (k == poke_at) begin
          cmd_load = 1; addr = ~exp_addr(); bvalid = 1; bdata = 8'h5A; stop = 1;
        end else begin
          cmd_load = 0; bvalid = 0; stop = 0;
        end
        @(negedge clk);
      end
      cmd_load = 0; bvalid = 0; stop = 0;
      chk(busy == 1'b0, "R3 end", busy, 0);
      m_val = '0;
      if (poke_at >= 0) chk(addr_out == exp_addr(), "R7 addr", addr_out, exp_addr());
    end else begin
      chk(mem_we == 1'b0, "R5 we", mem_we, 0);
    end
    check_row(m_row);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    m_val = '0; m_row = '0; m_col = '0; m_wp = 0; m_act = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R9 busy", busy, 0);
    chk(mem_we == 0, "R9 we", mem_we, 0);
    chk(addr_out == 0, "R9 addr", addr_out, 0);
    for (int i = 0; i < 4; i++) begin
      rd_addr = AW'(i * 97); #1;
      chk(rd_data == 8'hFF, "R9 erased", rd_data, 8'hFF);
      chk(rd_data == m_mem[rd_addr], "R10 read", rd_data, m_mem[rd_addr]);
    end

    // R5: stop with no command, then zero-byte command
    do_stop(-1);
    do_load(9'h045, 0); do_stop(-1);
    // byte write
    do_load(9'h0C7, 0); do_byte(8'h3C); do_stop(-1);
    // R1 wrap from column 62
    do_load(9'h17E, 0);
    for (int i = 0; i < 5; i++) do_byte(8'h10 + 8'(i));
    do_stop(-1);
    // R2 overflow: 70 bytes
    do_load(9'h090, 0);
    for (int i = 0; i < 70; i++) do_byte(8'(i * 3 + 1));
    do_stop(-1);
    // R6 protected
    do_load(9'h123, 1);
    for (int i = 0; i < 4; i++) do_byte(8'hEE);
    do_stop(-1);
    // R7 pokes during busy, then lone stop must not commit
    do_load(9'h1C0, 0); do_byte(8'hA1); do_byte(8'hA2); do_stop(10);
    do_stop(-1);
    // R8: next command into same row commits only its columns
    do_load(9'h1C5, 0); do_byte(8'h77); do_stop(-1);

    for (int t = 0; t < 25; t++) begin
      logic [AW-1:0] a;
      logic w;
      int n;
      a = AW'($urandom);
      w = ($urandom % 4) == 0;
      n = $urandom % 90;
      do_load(a, w);
      for (int i = 0; i < n; i++) do_byte(8'($urandom));
      do_stop((t % 5 == 0) ? 20 : -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule